// File: doc/BRIEF.md
# Per-Core Local Interrupt Controller

This block collects the six interrupt sources that belong to a single core and turns them into that core's interrupt pin vector, its non-maskable request and its yield request. Four of the sources are hardware events (watchdog expiry, compare match, timer tick and performance-counter overflow). They arrive as single-cycle pulses from timer logic outside the block. The other two are software interrupts, which software raises and lowers by writing a dedicated register.

Each source has a pending bit and an enable bit. Each source also has a routing word that chooses a pin index and whether the source also drives the non-maskable or yield output. A small control word can put the core in external-controller mode, in which all pin outputs are held low. The same control word decides whether the timer and performance-counter sources use their routing words or a fixed default pin.

Software reaches the block through a plain register port. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Outputs are combinational from the registered state, so they change in the same cycle that the state changes.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset the pending bits, enable bits, control word and all routing words are zero. `pin_o`, `nmi_o` and `yield_o` are low, and every register reads back as zero.
- R2: A pulse on `hw_evt_i[k]` sets pending bit k. The bit order is watchdog 0, compare 1, timer 2, performance counter 3. The bit is set whether or not the source is enabled, and it stays set until a write of 1 to that bit at offset 0x04. If a pulse and a clear hit the same bit in the same cycle, the pulse wins.
- R3: A write to offset 0x20 sets software pending bit 4 to `wr_data[0]` and software pending bit 5 to `wr_data[1]`.
- R4: Writing 1s to offset 0x10 enables the matching sources, and writing 1s to offset 0x0C disables them. Zero bits leave the enables unchanged. The enables read back at offset 0x08. Writes to 0x08 have no effect.
- R5: A routing word uses bit 31 for "drive a pin" and bits 5:0 for the pin index. A source that is pending, enabled and has bit 31 set drives `pin_o[index]`. An index of `NUM_PINS` or more drives no pin.
- R6: Routing bit 30 sends the source to `nmi_o` and bit 29 sends it to `yield_o`, both gated by pending and enabled. A routing word reads back only bits 31, 30, 29 and 5:0; all other bits read as zero.
- R7: Control bit 1 makes the timer follow its routing word, and control bit 2 does the same for the performance counter. When that bit is 0, the source drives only pin `DEFAULT_PIN` (5) and its routing word is ignored.
- R8: Control bit 0 selects external-controller mode. In this mode `pin_o` is all zero, while `nmi_o` and `yield_o` keep working.
- R9: The control word reads at 0x00 (bits 2:0) and the pending bits read at 0x04. Routing words sit at 0x40 (watchdog), 0x44 (compare), 0x48 (timer), 0x50 (performance counter), 0x54 (software 0) and 0x58 (software 1). Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| hw_evt_i | input | 4 | Hardware event pulses (watchdog, compare, timer, perf counter) |
| pin_o | output | NUM_PINS | Interrupt pin vector to the core |
| nmi_o | output | 1 | Non-maskable interrupt request |
| yield_o | output | 1 | Yield request |

## Verification
A corrupted pending or enable bit shows up on `pin_o`, `nmi_o` or `yield_o` in the same cycle it is stored, because the outputs have no register stage after the state. A stale routing word or control bit shows the same way: a source lands on the wrong pin, falls back to pin 5 when it should not, or fails to fall back when it should. In external-controller mode, a leak appears as any nonzero pin. A pending bit that is latched while its source is disabled stays invisible at the outputs. The bench therefore reads it back at offset 0x04 before the source is enabled, and checks the clear-versus-pulse race through the same readback.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NSRC    = 6;
  localparam int NHW     = 4;
  localparam int CTL_W   = 3;
  localparam int IDX_W   = 6;

  // source positions in pending / enable vectors
  localparam int SRC_WDOG = 0;
  localparam int SRC_CMP  = 1;
  localparam int SRC_TMR  = 2;
  localparam int SRC_PERF = 3;
  localparam int SRC_SW0  = 4;

  // control word bits
  localparam int CTL_EXT  = 0;
  localparam int CTL_TMRR = 1;
  localparam int CTL_PRFR = 2;

  localparam logic [ADDR_W-1:0] OFF_CTL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ENCL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ENST = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_SOFT = 8'h20;

  typedef struct packed {
    logic             to_pin;
    logic             to_nmi;
    logic             to_yld;
    logic [IDX_W-1:0] idx;
  } route_t;

  // routing words: 0x40 upward, one word skipped after the timer slot
  function automatic logic [ADDR_W-1:0] route_off(input int s);
    return ADDR_W'(32'h40 + 4 * s + ((s >= 3) ? 4 : 0));
  endfunction
endpackage

// File: rtl/loc_irq_regs.sv
module loc_irq_regs
  import loc_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NHW-1:0]         hw_evt,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NSRC-1:0]        pend,
  output logic [NSRC-1:0]        en,
  output logic [CTL_W-1:0]       ctl,
  output route_t [NSRC-1:0]      route
);
  localparam int NSW = NSRC - NHW;

  logic hit_ctl, hit_pend, hit_encl, hit_enst, hit_soft;
  logic [NSRC-1:0] wbits;
  logic [NSRC-1:0] pend_nx, en_nx;
  logic unused_bits;

  assign hit_ctl  = wr_en && (wr_addr == OFF_CTL);
  assign hit_pend = wr_en && (wr_addr == OFF_PEND);
  assign hit_encl = wr_en && (wr_addr == OFF_ENCL);
  assign hit_enst = wr_en && (wr_addr == OFF_ENST);
  assign hit_soft = wr_en && (wr_addr == OFF_SOFT);
  assign wbits    = wr_data[NSRC-1:0];
  assign unused_bits = ^wr_data[28:NSRC];

  always_comb begin
    pend_nx = pend;
    for (int k = 0; k < NHW; k++) begin
      // pulse has priority over a software clear in the same cycle
      pend_nx[k] = hw_evt[k] | (pend[k] & ~(hit_pend & wbits[k]));
    end
    if (hit_soft) pend_nx[NSRC-1:NHW] = wr_data[NSW-1:0];
    en_nx = en;
    if (hit_encl) en_nx = en_nx & ~wbits;
    if (hit_enst) en_nx = en_nx | wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      en    <= '0;
      ctl   <= '0;
      route <= '0;
    end else begin
      pend <= pend_nx;
      en   <= en_nx;
      if (hit_ctl) ctl <= wr_data[CTL_W-1:0];
      for (int s = 0; s < NSRC; s++) begin
        if (wr_en && (wr_addr == route_off(s)))
          route[s] <= {wr_data[31], wr_data[30], wr_data[29], wr_data[IDX_W-1:0]};
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFF_CTL:  rd_data[CTL_W-1:0] = ctl;
      OFF_PEND: rd_data[NSRC-1:0]  = pend;
      OFF_EN:   rd_data[NSRC-1:0]  = en;
      default:  rd_data = '0;
    endcase
    for (int s = 0; s < NSRC; s++) begin
      if (rd_addr == route_off(s))
        rd_data = {route[s].to_pin, route[s].to_nmi, route[s].to_yld,
                   {(DATA_W-3-IDX_W){1'b0}}, route[s].idx};
    end
  end

  // R2: a hardware pulse always leaves its pending bit set
  p_pulse_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt) |=> ((pend[NHW-1:0] & $past(hw_evt)) == $past(hw_evt)));

  // R2: write-1 clear takes effect on bits without a concurrent pulse
  p_pend_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pend |=> ((pend[NHW-1:0] & $past(wbits[NHW-1:0] & ~hw_evt)) == '0));

  // R4: set port enables every written 1
  p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_enst |=> ((en & $past(wbits)) == $past(wbits)));

  // R4: clear port disables every written 1
  p_en_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_encl |=> ((en & $past(wbits)) == '0));

  // R4: a write to the enable readback offset changes nothing
  p_en_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_EN) |=> $stable(en));
endmodule

// File: rtl/loc_irq_route.sv
module loc_irq_route
  import loc_irq_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int DEFAULT_PIN = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      pend,
  input  logic [NSRC-1:0]      en,
  input  logic [CTL_W-1:0]     ctl,
  input  route_t [NSRC-1:0]    route,
  output logic [NUM_PINS-1:0]  pin_o,
  output logic                 nmi_o,
  output logic                 yield_o
);
  logic [NSRC-1:0][NUM_PINS-1:0] pin_vec;
  logic [NSRC-1:0]               nmi_vec, yld_vec, live;
  logic [NUM_PINS-1:0]           pins_any;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic fixed;
    assign live[s] = pend[s] & en[s];
    if (s == SRC_TMR) begin : g_tmr
      assign fixed = ~ctl[CTL_TMRR];
    end else if (s == SRC_PERF) begin : g_prf
      assign fixed = ~ctl[CTL_PRFR];
    end else begin : g_map
      assign fixed = 1'b0;
    end
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pin_vec[s][p] = live[s] &
        (fixed ? (p == DEFAULT_PIN)
               : (route[s].to_pin && route[s].idx == IDX_W'(p)));
    end
    assign nmi_vec[s] = live[s] & ~fixed & route[s].to_nmi;
    assign yld_vec[s] = live[s] & ~fixed & route[s].to_yld;
  end

  always_comb begin
    pins_any = '0;
    for (int s = 0; s < NSRC; s++) pins_any = pins_any | pin_vec[s];
  end

  assign pin_o   = ctl[CTL_EXT] ? '0 : pins_any;
  assign nmi_o   = |nmi_vec;
  assign yield_o = |yld_vec;

  // R8: external-controller mode silences every pin
  p_ext_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[CTL_EXT] |-> (pin_o == '0));

  // R5: any asserted output needs a source that is both pending and enabled
  p_out_needs_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_o != '0) || nmi_o || yield_o) |-> ((pend & en) != '0));

  // R7: a non-routable timer that is live keeps the default pin up
  p_tmr_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live[SRC_TMR] && !ctl[CTL_TMRR] && !ctl[CTL_EXT]) |-> pin_o[DEFAULT_PIN]);
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
  import loc_irq_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int DEFAULT_PIN = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [7:0]          rd_addr,
  output logic [31:0]         rd_data,
  input  logic [3:0]          hw_evt_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic                nmi_o,
  output logic                yield_o
);
  logic [NSRC-1:0]   pend, en;
  logic [CTL_W-1:0]  ctl;
  route_t [NSRC-1:0] route;

  loc_irq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .hw_evt  (hw_evt_i),
    .rd_data (rd_data),
    .pend    (pend),
    .en      (en),
    .ctl     (ctl),
    .route   (route)
  );

  loc_irq_route #(
    .NUM_PINS    (NUM_PINS),
    .DEFAULT_PIN (DEFAULT_PIN)
  ) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .en      (en),
    .ctl     (ctl),
    .route   (route),
    .pin_o   (pin_o),
    .nmi_o   (nmi_o),
    .yield_o (yield_o)
  );
endmodule

// File: tb/loc_irq_ctrl_tb.sv
module loc_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  hw_evt_i = '0;
  logic [5:0]  pin_o;
  logic        nmi_o, yield_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  loc_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .hw_evt_i(hw_evt_i), .pin_o(pin_o), .nmi_o(nmi_o), .yield_o(yield_o)
  );

  // vector: wr(1) addr(8) data(32) evt(4) exp_pin(6) exp_nmi(1) exp_yld(1)
  localparam int NV = 19;
  localparam logic [52:0] VECS [0:NV-1] = '{
    {1'b1, 8'h44, 32'h8000_0002, 4'h0, 6'b000000, 1'b0, 1'b0}, // R5 route cmp->pin2
    {1'b0, 8'h00, 32'h0,         4'h2, 6'b000000, 1'b0, 1'b0}, // R2 cmp pulse, disabled
    {1'b1, 8'h10, 32'h0000_0002, 4'h0, 6'b000100, 1'b0, 1'b0}, // R4 R5 enable cmp
    {1'b1, 8'h44, 32'hC000_0002, 4'h0, 6'b000100, 1'b1, 1'b0}, // R6 add nmi
    {1'b1, 8'h00, 32'h0000_0001, 4'h0, 6'b000000, 1'b1, 1'b0}, // R8 ext mode
    {1'b1, 8'h00, 32'h0000_0000, 4'h0, 6'b000100, 1'b1, 1'b0}, // R8 leave ext mode
    {1'b1, 8'h04, 32'h0000_0002, 4'h0, 6'b000000, 1'b0, 1'b0}, // R2 clear cmp
    {1'b0, 8'h00, 32'h0,         4'h4, 6'b000000, 1'b0, 1'b0}, // R2 timer pulse
    {1'b1, 8'h10, 32'h0000_0004, 4'h0, 6'b100000, 1'b0, 1'b0}, // R7 default pin
    {1'b1, 8'h48, 32'h6000_0001, 4'h0, 6'b100000, 1'b0, 1'b0}, // R7 map ignored
    {1'b1, 8'h00, 32'h0000_0002, 4'h0, 6'b000000, 1'b1, 1'b1}, // R7 R6 routable
    {1'b1, 8'h0C, 32'h0000_0004, 4'h0, 6'b000000, 1'b0, 1'b0}, // R4 disable timer
    {1'b1, 8'h08, 32'h0000_003F, 4'h0, 6'b000000, 1'b0, 1'b0}, // R4 readback offset ignored
    {1'b1, 8'h20, 32'h0000_0001, 4'h0, 6'b000000, 1'b0, 1'b0}, // R3 raise sw0
    {1'b1, 8'h54, 32'h8000_0000, 4'h0, 6'b000000, 1'b0, 1'b0}, // R5 sw0->pin0
    {1'b1, 8'h10, 32'h0000_0010, 4'h0, 6'b000001, 1'b0, 1'b0}, // R3 R5 enable sw0
    {1'b1, 8'h54, 32'h8000_0007, 4'h0, 6'b000000, 1'b0, 1'b0}, // R5 index out of range
    {1'b1, 8'h54, 32'h8000_0000, 4'h0, 6'b000001, 1'b0, 1'b0}, // R5 back to pin0
    {1'b1, 8'h20, 32'h0000_0000, 4'h0, 6'b000000, 1'b0, 1'b0}  // R3 lower sw0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, return after the next falling edge
  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] e);
    wr_en = w; wr_addr = a; wr_data = d; hw_evt_i = e;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; hw_evt_i = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic outs(input string req, input logic [7:0] exp);
    chk(req, {24'h0, pin_o, nmi_o, yield_o}, {24'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    outs("R1", 8'h00);
    rd("R1", 8'h00, 32'h0);
    rd("R1", 8'h04, 32'h0);
    rd("R1", 8'h08, 32'h0);
    rd("R1", 8'h44, 32'h0);

    for (int v = 0; v < NV; v++) begin
      cyc(VECS[v][52], VECS[v][51:44], VECS[v][43:12], VECS[v][11:8]);
      chk($sformatf("vector %0d", v), {24'h0, pin_o, nmi_o, yield_o},
          {24'h0, VECS[v][7:0]});
    end

    // R4 enable readback: cmp and sw0 enabled
    rd("R4", 8'h08, 32'h0000_0012);
    // R2 timer still pending while disabled
    rd("R2", 8'h04, 32'h0000_0004);
    // R2 pulse wins over a same-cycle clear
    cyc(1'b1, 8'h04, 32'h0000_0001, 4'h1);
    rd("R2", 8'h04, 32'h0000_0005);
    cyc(1'b1, 8'h04, 32'h0000_0005, 4'h0);
    rd("R2", 8'h04, 32'h0000_0000);
    // R9 offsets and R6 readback of routing bits only
    cyc(1'b1, 8'h40, 32'hFFFF_FFFF, 4'h0);
    rd("R6", 8'h40, 32'hE000_003F);
    rd("R9", 8'h48, 32'h6000_0001);
    rd("R9", 8'h4C, 32'h0);
    rd("R9", 8'h00, 32'h0000_0002);
    cyc(1'b1, 8'h58, 32'h2000_0003, 4'h0);
    rd("R9", 8'h58, 32'h2000_0003);
    rd("R9", 8'h54, 32'h8000_0000);
    // R7 perf counter default pin, then routable with empty map
    cyc(1'b0, 8'h00, 32'h0, 4'h8);
    cyc(1'b1, 8'h10, 32'h0000_0008, 4'h0);
    outs("R7", {6'b100000, 2'b00});
    cyc(1'b1, 8'h00, 32'h0000_0006, 4'h0);
    outs("R7", 8'h00);
    // R1 reset in mid-run
    rst_n = 1'b0;
    #1;
    outs("R1", 8'h00);
    rd("R1", 8'h08, 32'h0);
    rd("R1", 8'h40, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule